// File: doc/BRIEF.md
# Segmented Virtual Address Translator with Fault Capture

This block sits in the address path ahead of a TLB. Each cycle it may accept one 32-bit virtual address, with a write flag, a user-mode flag and an error-level flag. It sorts the address into fixed windows by its top bits and handles it in one of three ways. It rejects a user-mode access to the upper half of the address space. It translates the two direct windows by removing a fixed offset. For the mapped windows it passes the request to a combinational TLB lookup port and uses the result that port returns in the same cycle.

The outcome is registered and appears one cycle after the request. A success returns a physical address and read/write permission. A failure returns an exception strobe, an exception code and a refill flag. On the same edge as a failure, three fault-context registers capture the failing address: the bad address, a page-table context word and an entry-high word. Software can preload the upper part of the context word and the address-space identifier through two write enables that share one data bus.

Top module: `seg_xlate`

## Requirements
- R1: While reset is asserted and after it is released, ok_vld, exc_vld, exc_refill, perm_rd and perm_wr are 0, exc_kind is 0, and bad_vaddr, context_reg and entryhi_reg are 0.
- R2: A user-mode request whose address has bit 31 set fails with exc_kind 4 on a read or 5 on a write, with exc_refill 0 and no TLB request. This check takes precedence over the error-level flag.
- R3: A request with bit 31 clear and err_level set succeeds with paddr equal to vaddr, perm_rd 1 and perm_wr 1, and raises no TLB request.
- R4: A request with bit 31 clear and err_level clear drives tlb_req_vld, with tlb_vaddr and tlb_is_write equal to the request. A hit (tlb_result 0) succeeds with paddr equal to tlb_paddr, perm_rd 1 and perm_wr equal to tlb_wr_ok.
- R5: Addresses 0x80000000 to 0x9FFFFFFF succeed with paddr equal to vaddr minus 0x80000000. Addresses 0xA0000000 to 0xBFFFFFFF succeed with paddr equal to vaddr minus 0xA0000000. Both get perm_rd 1 and perm_wr 1 and raise no TLB request.
- R6: Addresses from 0xC0000000 upward, outside user mode, go through the TLB port exactly as in R4.
- R7: A TLB no-match (tlb_result 1) fails with exc_kind 2 on a read or 3 on a write, with exc_refill 1.
- R8: A TLB invalid result (tlb_result 2) fails with exc_kind 2 on a read or 3 on a write, with exc_refill 0.
- R9: A TLB modify result (tlb_result 3) fails with exc_kind 1 and exc_refill 0.
- R10: On a failure, bad_vaddr takes vaddr. context_reg keeps bits 31:23 and takes vaddr[31:13] into bits 22:4, with bits 3:0 zero. entryhi_reg takes vaddr[31:13] into bits 31:13, with bits 12:8 zero, and keeps bits 7:0.
- R11: Results appear exactly one cycle after the request as a one-cycle ok_vld or exc_vld pulse, never both. A success or an idle cycle leaves the three fault registers unchanged.
- R12: cfg_ctx_we loads context_reg[31:23] from cfg_wdata[31:23], and cfg_asid_we loads entryhi_reg[7:0] from cfg_wdata[7:0]. A failure in the same cycle overrides both writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Translation request this cycle |
| vaddr | input | 32 | Virtual address |
| is_write | input | 1 | 1 = store, 0 = load |
| user_mode | input | 1 | Request issued in user mode |
| err_level | input | 1 | Error level active; low half is identity-mapped |
| tlb_req_vld | output | 1 | Lookup request to the TLB |
| tlb_vaddr | output | 32 | Address presented to the TLB |
| tlb_is_write | output | 1 | Direction presented to the TLB |
| tlb_result | input | 2 | Same-cycle TLB result: 0 hit, 1 no-match, 2 invalid, 3 modify |
| tlb_paddr | input | 32 | Physical address returned on a hit |
| tlb_wr_ok | input | 1 | Hit page is writable |
| cfg_ctx_we | input | 1 | Load context_reg[31:23] |
| cfg_asid_we | input | 1 | Load entryhi_reg[7:0] |
| cfg_wdata | input | 32 | Data for both config writes |
| ok_vld | output | 1 | Successful translation strobe |
| paddr | output | 32 | Physical address, valid with ok_vld |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |
| exc_vld | output | 1 | Exception strobe |
| exc_kind | output | 3 | Exception code: 1 modify, 2 TLB load, 3 TLB store, 4 address-error load, 5 address-error store |
| exc_refill | output | 1 | Exception came from a TLB no-match |
| bad_vaddr | output | 32 | Captured failing address |
| context_reg | output | 32 | Page-table context word |
| entryhi_reg | output | 32 | Entry-high word: page number and ASID |

## Verification
The hardest case to reach is a failure that lands in the same cycle as one or both configuration writes. There the capture must override the write in context_reg and entryhi_reg, while the preserved fields keep their earlier values and do not take the write data. The bench first preloads distinctive context and ASID values, then raises faults with both write enables set and different data on cfg_wdata. It also interleaves successful translations between faults, to show that the captured state survives them unchanged.

// File: rtl/xl_pkg.sv
package xl_pkg;

  typedef enum logic [1:0] {
    TLB_HIT   = 2'd0,
    TLB_MISS  = 2'd1,
    TLB_INVAL = 2'd2,
    TLB_MOD   = 2'd3
  } tlb_res_e;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_MOD  = 3'd1,
    EXC_TLBL = 3'd2,
    EXC_TLBS = 3'd3,
    EXC_ADEL = 3'd4,
    EXC_ADES = 3'd5
  } exc_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_BAD   = 3'd1,
    FLT_MISS  = 3'd2,
    FLT_INVAL = 3'd3,
    FLT_MOD   = 3'd4
  } flt_e;

  typedef enum logic [1:0] {
    SEG_LOW    = 2'd0,
    SEG_DIRECT = 2'd1,
    SEG_MAPHI  = 2'd2
  } seg_e;

endpackage

// File: rtl/xl_seg_decode.sv
module xl_seg_decode
  import xl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              user_mode,
  input  logic              err_level,
  output seg_e              seg,
  output logic              bad_addr,
  output logic              needs_tlb,
  output logic [ADDR_W-1:0] direct_pa
);
  // Top three bits pick the window; the direct windows are 2^(ADDR_W-3) each.
  localparam int WIN_LSB = ADDR_W - 3;

  logic [2:0] top;

  always_comb begin
    top = vaddr[ADDR_W-1 -: 3];
    if (!top[2]) begin
      seg = SEG_LOW;
    end else if (!top[1]) begin
      seg = SEG_DIRECT;
    end else begin
      seg = SEG_MAPHI;
    end
  end

  always_comb begin
    bad_addr  = user_mode && top[2];
    needs_tlb = 1'b0;
    direct_pa = '0;
    if (!bad_addr) begin
      unique case (seg)
        SEG_LOW: begin
          if (err_level) begin
            direct_pa = vaddr;
          end else begin
            needs_tlb = 1'b1;
          end
        end
        SEG_DIRECT: begin
          // Subtracting the window base equals clearing the three top bits.
          direct_pa = {3'b000, vaddr[WIN_LSB-1:0]};
        end
        default: begin
          needs_tlb = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/xl_fault_classify.sv
module xl_fault_classify
  import xl_pkg::*;
(
  input  flt_e fault,
  input  logic is_write,
  output exc_e kind,
  output logic refill
);
  always_comb begin
    kind   = EXC_NONE;
    refill = 1'b0;
    unique case (fault)
      FLT_BAD:   kind = is_write ? EXC_ADES : EXC_ADEL;
      FLT_MISS: begin
        kind   = is_write ? EXC_TLBS : EXC_TLBL;
        refill = 1'b1;
      end
      FLT_INVAL: kind = is_write ? EXC_TLBS : EXC_TLBL;
      FLT_MOD:   kind = EXC_MOD;
      default:   kind = EXC_NONE;
    endcase
  end
endmodule

// File: rtl/xl_fault_regs.sv
module xl_fault_regs #(
  parameter int ADDR_W   = 32,
  parameter int ASID_W   = 8,
  parameter int PAGE_LSB = 13,
  parameter int CTX_KEEP = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              ctx_we,
  input  logic              asid_we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] bad_vaddr,
  output logic [ADDR_W-1:0] context_reg,
  output logic [ADDR_W-1:0] entryhi_reg
);
  localparam int VPN_W   = ADDR_W - PAGE_LSB;
  localparam int KEEP_W  = ADDR_W - CTX_KEEP;
  localparam int CPAD_W  = CTX_KEEP - VPN_W;
  localparam int HGAP_W  = PAGE_LSB - ASID_W;

  logic [ADDR_W-1:0] badv_d, ctx_d, hi_d;
  logic              badv_en, ctx_en, hi_en;

  always_comb begin
    badv_d  = bad_vaddr;
    ctx_d   = context_reg;
    hi_d    = entryhi_reg;
    badv_en = capture;
    ctx_en  = capture || ctx_we;
    hi_en   = capture || asid_we;
    if (capture) begin
      badv_d = vaddr;
      ctx_d  = {context_reg[ADDR_W-1 -: KEEP_W], vaddr[ADDR_W-1 -: VPN_W], {CPAD_W{1'b0}}};
      hi_d   = {vaddr[ADDR_W-1 -: VPN_W], {HGAP_W{1'b0}}, entryhi_reg[ASID_W-1:0]};
    end else begin
      if (ctx_we) begin
        ctx_d[ADDR_W-1 -: KEEP_W] = wdata[ADDR_W-1 -: KEEP_W];
      end
      if (asid_we) begin
        hi_d[ASID_W-1:0] = wdata[ASID_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_vaddr   <= '0;
      context_reg <= '0;
      entryhi_reg <= '0;
    end else begin
      if (badv_en) bad_vaddr   <= badv_d;
      if (ctx_en)  context_reg <= ctx_d;
      if (hi_en)   entryhi_reg <= hi_d;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import xl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ASID_W   = 8,
  parameter int PAGE_LSB = 13,
  parameter int CTX_KEEP = 23,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              is_write,
  input  logic              user_mode,
  input  logic              err_level,
  output logic              tlb_req_vld,
  output logic [ADDR_W-1:0] tlb_vaddr,
  output logic              tlb_is_write,
  input  logic [1:0]        tlb_result,
  input  logic [ADDR_W-1:0] tlb_paddr,
  input  logic              tlb_wr_ok,
  input  logic              cfg_ctx_we,
  input  logic              cfg_asid_we,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              ok_vld,
  output logic [ADDR_W-1:0] paddr,
  output logic              perm_rd,
  output logic              perm_wr,
  output logic              exc_vld,
  output logic [2:0]        exc_kind,
  output logic              exc_refill,
  output logic [ADDR_W-1:0] bad_vaddr,
  output logic [ADDR_W-1:0] context_reg,
  output logic [ADDR_W-1:0] entryhi_reg
);

  // Reset: asserted asynchronously, released through a synchronizer chain.
  logic [SYNC_STG-1:0] rst_pipe;
  logic                rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STG-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STG-1];

  // Segment decode
  seg_e              seg;
  logic              bad_addr, needs_tlb;
  logic [ADDR_W-1:0] direct_pa;

  xl_seg_decode #(.ADDR_W(ADDR_W)) u_seg (
    .vaddr     (vaddr),
    .user_mode (user_mode),
    .err_level (err_level),
    .seg       (seg),
    .bad_addr  (bad_addr),
    .needs_tlb (needs_tlb),
    .direct_pa (direct_pa)
  );

  assign tlb_req_vld  = req_vld && needs_tlb;
  assign tlb_vaddr    = vaddr;
  assign tlb_is_write = is_write;

  // Outcome selection
  flt_e              fault;
  logic              ok_d;
  logic [ADDR_W-1:0] pa_d;
  logic              wr_d;
  tlb_res_e          tres;

  always_comb begin
    tres  = tlb_res_e'(tlb_result);
    fault = FLT_NONE;
    ok_d  = 1'b0;
    pa_d  = direct_pa;
    wr_d  = 1'b1;
    if (req_vld) begin
      if (bad_addr) begin
        fault = FLT_BAD;
      end else if (needs_tlb) begin
        unique case (tres)
          TLB_HIT: begin
            ok_d = 1'b1;
            pa_d = tlb_paddr;
            wr_d = tlb_wr_ok;
          end
          TLB_MISS:  fault = FLT_MISS;
          TLB_INVAL: fault = FLT_INVAL;
          default:   fault = FLT_MOD;
        endcase
      end else begin
        ok_d = 1'b1;
      end
    end
  end

  exc_e kind_d;
  logic refill_d;

  xl_fault_classify u_cls (
    .fault    (fault),
    .is_write (is_write),
    .kind     (kind_d),
    .refill   (refill_d)
  );

  logic capture;
  assign capture = (fault != FLT_NONE);

  // Result registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ok_vld     <= 1'b0;
      exc_vld    <= 1'b0;
      exc_kind   <= EXC_NONE;
      exc_refill <= 1'b0;
      perm_rd    <= 1'b0;
      perm_wr    <= 1'b0;
      paddr      <= '0;
    end else begin
      ok_vld     <= ok_d;
      exc_vld    <= capture;
      exc_kind   <= kind_d;
      exc_refill <= refill_d;
      perm_rd    <= ok_d;
      perm_wr    <= ok_d && wr_d;
      if (ok_d) paddr <= pa_d;
    end
  end

  xl_fault_regs #(
    .ADDR_W   (ADDR_W),
    .ASID_W   (ASID_W),
    .PAGE_LSB (PAGE_LSB),
    .CTX_KEEP (CTX_KEEP)
  ) u_fregs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .capture     (capture),
    .vaddr       (vaddr),
    .ctx_we      (cfg_ctx_we),
    .asid_we     (cfg_asid_we),
    .wdata       (cfg_wdata),
    .bad_vaddr   (bad_vaddr),
    .context_reg (context_reg),
    .entryhi_reg (entryhi_reg)
  );

endmodule

// File: rtl/xl_checker.sv
module xl_checker #(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [ADDR_W-1:0] vaddr,
  input logic              is_write,
  input logic              user_mode,
  input logic              tlb_req_vld,
  input logic              ok_vld,
  input logic [ADDR_W-1:0] paddr,
  input logic              exc_vld,
  input logic [2:0]        exc_kind,
  input logic              exc_refill,
  input logic [ADDR_W-1:0] bad_vaddr,
  input logic [ADDR_W-1:0] entryhi_reg
);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_vld && exc_vld));

  a_r2_user_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && user_mode && vaddr[ADDR_W-1]) |=>
      (exc_vld && !exc_refill && (exc_kind == ($past(is_write) ? 3'd5 : 3'd4))));

  a_r2_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && user_mode && vaddr[ADDR_W-1]) |-> !tlb_req_vld);

  a_r5_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !user_mode && vaddr[ADDR_W-1 -: 2] == 2'b10) |=>
      (ok_vld && paddr == {3'b000, $past(vaddr[ADDR_W-4:0])}));

  a_r7_refill_kind: assert property (@(posedge clk) disable iff (!rst_n)
    exc_refill |-> (exc_vld && (exc_kind == 3'd2 || exc_kind == 3'd3)));

  a_r10_badv: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> (bad_vaddr == $past(vaddr)));

  a_r10_asid_kept: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> (entryhi_reg[ASID_W-1:0] == $past(entryhi_reg[ASID_W-1:0])));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_vld |-> $stable(bad_vaddr));

endmodule

bind seg_xlate xl_checker #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_vld     (req_vld),
  .vaddr       (vaddr),
  .is_write    (is_write),
  .user_mode   (user_mode),
  .tlb_req_vld (tlb_req_vld),
  .ok_vld      (ok_vld),
  .paddr       (paddr),
  .exc_vld     (exc_vld),
  .exc_kind    (exc_kind),
  .exc_refill  (exc_refill),
  .bad_vaddr   (bad_vaddr),
  .entryhi_reg (entryhi_reg)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, is_write, user_mode, err_level;
  logic [31:0] vaddr;
  logic        tlb_req_vld, tlb_is_write;
  logic [31:0] tlb_vaddr;
  logic [1:0]  tlb_result;
  logic [31:0] tlb_paddr;
  logic        tlb_wr_ok;
  logic        cfg_ctx_we, cfg_asid_we;
  logic [31:0] cfg_wdata;
  logic        ok_vld, perm_rd, perm_wr, exc_vld, exc_refill;
  logic [31:0] paddr, bad_vaddr, context_reg, entryhi_reg;
  logic [2:0]  exc_kind;

  always #4 clk = ~clk;

  seg_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .vaddr(vaddr),
    .is_write(is_write), .user_mode(user_mode), .err_level(err_level),
    .tlb_req_vld(tlb_req_vld), .tlb_vaddr(tlb_vaddr), .tlb_is_write(tlb_is_write),
    .tlb_result(tlb_result), .tlb_paddr(tlb_paddr), .tlb_wr_ok(tlb_wr_ok),
    .cfg_ctx_we(cfg_ctx_we), .cfg_asid_we(cfg_asid_we), .cfg_wdata(cfg_wdata),
    .ok_vld(ok_vld), .paddr(paddr), .perm_rd(perm_rd), .perm_wr(perm_wr),
    .exc_vld(exc_vld), .exc_kind(exc_kind), .exc_refill(exc_refill),
    .bad_vaddr(bad_vaddr), .context_reg(context_reg), .entryhi_reg(entryhi_reg)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          stamp;
    string       tag;
    bit          ok;
    bit          exc;
    logic [2:0]  kind;
    bit          refill;
    logic [31:0] pa;
    bit          wr;
    logic [31:0] badv;
    logic [31:0] ctx;
    logic [31:0] hi;
  } item_t;

  item_t sb[$];

  logic [31:0] m_badv = '0, m_ctx = '0, m_hi = '0;

  task automatic check(bit cond, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Driver: called just after a falling edge; computes the expected result.
  task automatic send(bit rv, logic [31:0] va, bit wr, bit usr, bit erl,
                      logic [1:0] tres, logic [31:0] tpa, bit twok,
                      bit cctx, bit casid, logic [31:0] wd, string tag);
    item_t it;
    bit    mapped;
    req_vld = rv; vaddr = va; is_write = wr; user_mode = usr; err_level = erl;
    tlb_result = tres; tlb_paddr = tpa; tlb_wr_ok = twok;
    cfg_ctx_we = cctx; cfg_asid_we = casid; cfg_wdata = wd;
    it.stamp = cyc; it.tag = tag; it.ok = 0; it.exc = 0; it.kind = 3'd0;
    it.refill = 0; it.pa = '0; it.wr = 0;
    mapped = 0;
    if (rv) begin
      if (usr && va[31]) begin
        it.exc = 1; it.kind = wr ? 3'd5 : 3'd4;
      end else if (!va[31] && erl) begin
        it.ok = 1; it.pa = va; it.wr = 1;
      end else if (va[31:30] == 2'b10) begin
        it.ok = 1; it.pa = va & 32'h1FFF_FFFF; it.wr = 1;
      end else begin
        mapped = 1;
        case (tres)
          2'd0: begin it.ok = 1; it.pa = tpa; it.wr = twok; end
          2'd1: begin it.exc = 1; it.kind = wr ? 3'd3 : 3'd2; it.refill = 1; end
          2'd2: begin it.exc = 1; it.kind = wr ? 3'd3 : 3'd2; end
          default: begin it.exc = 1; it.kind = 3'd1; end
        endcase
      end
    end
    if (it.exc) begin
      m_badv = va;
      m_ctx  = {m_ctx[31:23], va[31:13], 4'b0000};
      m_hi   = {va[31:13], 5'b00000, m_hi[7:0]};
    end else begin
      if (cctx)  m_ctx[31:23] = wd[31:23];
      if (casid) m_hi[7:0]    = wd[7:0];
    end
    it.badv = m_badv; it.ctx = m_ctx; it.hi = m_hi;
    #1;
    check(tlb_req_vld == mapped, {tag, " (R4/R6) tlb_req_vld"}, 32'(tlb_req_vld), 32'(mapped));
    if (mapped) begin
      check(tlb_vaddr == va && tlb_is_write == wr, {tag, " (R4) tlb address/dir"}, tlb_vaddr, va);
    end
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    send(0, 32'h0, 0, 0, 0, 2'd0, 32'h0, 0, 0, 0, 32'h0, tag);
  endtask

  // Monitor: compares each result one cycle after its request.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].stamp < cyc) begin
      item_t e;
      e = sb.pop_front();
      check(ok_vld == e.ok, {e.tag, " ok_vld (R11)"}, 32'(ok_vld), 32'(e.ok));
      check(exc_vld == e.exc, {e.tag, " exc_vld (R11)"}, 32'(exc_vld), 32'(e.exc));
      check(exc_kind == e.kind, {e.tag, " exc_kind"}, 32'(exc_kind), 32'(e.kind));
      check(exc_refill == e.refill, {e.tag, " exc_refill"}, 32'(exc_refill), 32'(e.refill));
      if (e.ok) begin
        check(paddr == e.pa, {e.tag, " paddr"}, paddr, e.pa);
        check(perm_rd == 1'b1 && perm_wr == e.wr, {e.tag, " perm"},
              {30'd0, perm_rd, perm_wr}, {30'd0, 1'b1, e.wr});
      end
      check(bad_vaddr == e.badv, {e.tag, " bad_vaddr (R10/R11)"}, bad_vaddr, e.badv);
      check(context_reg == e.ctx, {e.tag, " context_reg (R10/R12)"}, context_reg, e.ctx);
      check(entryhi_reg == e.hi, {e.tag, " entryhi_reg (R10/R12)"}, entryhi_reg, e.hi);
    end
  end

  initial begin
    rst_n = 1'b0;
    req_vld = 0; vaddr = '0; is_write = 0; user_mode = 0; err_level = 0;
    tlb_result = '0; tlb_paddr = '0; tlb_wr_ok = 0;
    cfg_ctx_we = 0; cfg_asid_we = 0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    check(!ok_vld && !exc_vld && exc_kind == 0 && !exc_refill && !perm_rd && !perm_wr,
          "R1 strobes in reset", {26'd0, ok_vld, exc_vld, exc_kind[1:0], perm_rd, perm_wr}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(bad_vaddr == 0 && context_reg == 0 && entryhi_reg == 0,
          "R1 fault regs after reset", bad_vaddr | context_reg | entryhi_reg, 32'd0);
    check(!ok_vld && !exc_vld, "R1 no strobe after reset", {30'd0, ok_vld, exc_vld}, 32'd0);

    // R5 direct windows, including edges
    send(1, 32'h8123_4560, 0, 0, 0, 2'd1, 32'h0, 0, 0, 0, 0, "R5 low direct");
    send(1, 32'hA000_0010, 1, 0, 0, 2'd1, 32'h0, 0, 0, 0, 0, "R5 high direct");
    send(1, 32'h9FFF_FFFC, 0, 0, 1, 2'd1, 32'h0, 0, 0, 0, 0, "R5 window top");
    send(1, 32'hBFFF_FFFF, 1, 0, 0, 2'd1, 32'h0, 0, 0, 0, 0, "R5 second window top");
    // R3 identity with error level
    send(1, 32'h0000_1234, 1, 0, 1, 2'd1, 32'h0, 0, 0, 0, 0, "R3 identity");
    send(1, 32'h7FFF_FFFF, 0, 1, 1, 2'd1, 32'h0, 0, 0, 0, 0, "R3 user identity top");
    // R12 preload context and ASID
    send(0, 32'h0, 0, 0, 0, 2'd0, 32'h0, 0, 1, 1, 32'hAB80_005A, "R12 config load");
    // R2 user-mode faults
    send(1, 32'h8000_0000, 0, 1, 0, 2'd0, 32'h0, 0, 0, 0, 0, "R2 user load");
    send(1, 32'hFFFF_FFFF, 1, 1, 1, 2'd0, 32'h0, 0, 0, 0, 0, "R2 user store erl");
    // R4 / R6 hits
    send(1, 32'h0040_2ABC, 1, 0, 0, 2'd0, 32'h0034_5ABC, 0, 0, 0, 0, "R4 low hit ro");
    send(1, 32'hC000_1000, 0, 0, 0, 2'd0, 32'h1234_5000, 1, 0, 0, 0, "R6 high hit rw");
    send(1, 32'h7FFF_E000, 0, 1, 0, 2'd0, 32'h0FFF_E000, 1, 0, 0, 0, "R4 user low hit");
    // R7 / R8 / R9 faults
    send(1, 32'h1234_5678, 0, 0, 0, 2'd1, 32'h0, 0, 0, 0, 0, "R7 miss load");
    send(1, 32'hE000_0000, 1, 0, 0, 2'd1, 32'h0, 0, 0, 0, 0, "R7 miss store");
    send(1, 32'h0000_2000, 0, 0, 0, 2'd2, 32'h0, 0, 0, 0, 0, "R8 invalid load");
    send(1, 32'hFFFF_E000, 1, 0, 0, 2'd2, 32'h0, 0, 0, 0, 0, "R8 invalid store");
    send(1, 32'hD555_5555, 1, 0, 0, 2'd3, 32'h0, 0, 0, 0, 0, "R9 modify");
    // R11 success after fault keeps captured state; idle too
    send(1, 32'h8000_0004, 0, 0, 0, 2'd1, 32'h0, 0, 0, 0, 0, "R11 success hold");
    idle("R11 idle hold");
    // R12 fault overrides same-cycle config writes
    send(1, 32'h0ACE_1000, 1, 0, 0, 2'd1, 32'h0, 0, 1, 1, 32'h5500_00C3, "R12 fault beats cfg");
    send(0, 32'h0, 0, 0, 0, 2'd0, 32'h0, 0, 1, 0, 32'h1F80_00FF, "R12 ctx only");
    send(0, 32'h0, 0, 0, 0, 2'd0, 32'h0, 0, 0, 1, 32'hFFFF_FF11, "R12 asid only");
    send(1, 32'h3000_0000, 0, 0, 0, 2'd2, 32'h0, 0, 0, 0, 0, "R10 capture after cfg");
    // back-to-back mixed traffic
    for (int i = 0; i < 16; i++) begin
      send(1, 32'h1357_9BDF * (i + 1), i[0], i[1], i[2], 2'(i), 32'h0002_4680 + 32'(i), i[3],
           i[1], i[2], 32'h6DB6_DB00 ^ 32'(i * 7), "R11 stream");
    end
    idle("R11 drain");
    idle("R11 drain");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule